// File: doc/BRIEF.md
# Two-Line Control Pattern Detector

This block watches two open-drain lines, A and B, that carry both data and clock. It picks out the control patterns that open a transaction. The detector arms when A is low while B is high. While armed, it counts falling edges on B. When A next rises, it classifies the count and gives one single-cycle pulse that names the outcome. The outcomes are a plain start, a start that announces a trailing CRC, a bus-occupancy claim, a line reset, or a frame error.

The two start outcomes also give an "enter data phase" pulse. They then hold the detector in a data-phase state, where it ignores all line activity. It stays there until the downstream byte logic raises `dataDone`. The other outcomes send the detector straight back to looking for a new pattern.

The raw lines are asynchronous. Each one passes through a two-flop synchronizer. Edges are found by comparing each synchronized sample with the sample from the previous clock.

Top module: `twoline_pattern_detect`

## Requirements
- R1: The detector arms only when synchronized A is low and synchronized B is high at the same time. A and B both low does not arm it.
- R2: While armed, every falling edge of B is counted. No outcome is produced until A rises, however long A stays low.
- R3: A rises with B high after exactly 4 B falls. This gives one `startPulse` together with one `dataPhasePulse`.
- R4: A rises with B high after exactly 6 B falls. This gives one `startCrcPulse` together with one `dataPhasePulse`.
- R5: A rises with B high after exactly 8 B falls. This gives one `occupancyPulse` and no `dataPhasePulse`, and `dataPhase` stays low.
- R6: A rises with B high after 14 or more B falls. This gives `resetPulse`. The count saturates at 15, so 20 falls still give reset and not a wrapped value.
- R7: A rises with B high after any other count (for example 0, 5, 7 or 13). This gives `frameErrPulse`.
- R8: A rises while B is low. This gives `frameErrPulse` whatever the count is, including a count of 4.
- R9: Each resolution raises exactly one of the five outcome pulses, for exactly one clock cycle.
- R10: `busy` is high from the cycle after arming until the outcome pulse. It falls in the same cycle the pulse appears.
- R11: After a start outcome, `dataPhase` is high and the detector does not arm or pulse on line activity. A `dataDone` pulse returns it to looking for patterns.
- R12: While `rstN` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineA | input | 1 | Raw line A, asynchronous |
| lineB | input | 1 | Raw line B, asynchronous |
| dataDone | input | 1 | Data phase finished; resume pattern search |
| startPulse | output | 1 | Start pattern recognised |
| startCrcPulse | output | 1 | Start-with-CRC pattern recognised |
| occupancyPulse | output | 1 | Occupancy pattern recognised |
| resetPulse | output | 1 | Reset pattern recognised |
| frameErrPulse | output | 1 | Pattern malformed |
| dataPhasePulse | output | 1 | Handing control to the data phase |
| busy | output | 1 | A pattern is being counted |
| dataPhase | output | 1 | Detector parked in the data phase |

## Verification
The bench drives B-fall counts of 0, 4, 5, 6, 7, 8, 13, 14 and 20 before A rises. Each count tests one boundary of the classification:
- 5, 7 and 13 test the neighbours of the valid counts.
- 14 is the reset threshold.
- 20 would wrap to a start code if the counter did not saturate.

A count of 3 followed by a final B fall, with B held low as A rises, tells the B-level check apart from the count check. Two further cases cover the rest:
- The case of A low with B low, then B rising, shows that arming needs both levels at once.
- An occupancy-shaped pattern sent during the data phase shows that the detector ignores line activity until `dataDone`.

// File: rtl/twoline_pkg.sv
package twoline_pkg;

  localparam int NUM_LINES = 2;
  localparam int LINE_A    = 0;
  localparam int LINE_B    = 1;

  typedef enum logic [2:0] {
    PC_NONE,
    PC_START,
    PC_START_CRC,
    PC_OCCUPY,
    PC_RESET,
    PC_FRAME_ERR
  } patClass_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_DATA
  } detState_t;

  typedef struct packed {
    logic clearCount;
    logic countEn;
  } ctrlStrobes_t;

endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RESET_VAL}};
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/pattern_datapath.sv
module pattern_datapath
  import twoline_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int CNT_W         = 4,
  parameter int START_CNT     = 4,
  parameter int START_CRC_CNT = 6,
  parameter int OCCUPY_CNT    = 8,
  parameter int RESET_MIN     = 14
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         lineA,
  input  logic         lineB,
  input  ctrlStrobes_t strobes,
  output logic         aLevel,
  output logic         bLevel,
  output logic         aRise,
  output patClass_t    patClass
);

  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] K_START   = CNT_W'(START_CNT);
  localparam logic [CNT_W-1:0] K_CRC     = CNT_W'(START_CRC_CNT);
  localparam logic [CNT_W-1:0] K_OCCUPY  = CNT_W'(OCCUPY_CNT);
  localparam logic [CNT_W-1:0] K_RST_MIN = CNT_W'(RESET_MIN);

  logic [NUM_LINES-1:0] rawLines;
  logic [NUM_LINES-1:0] syncLines;
  logic [NUM_LINES-1:0] prevLines;
  logic [CNT_W-1:0]     fallCount;
  logic                 bFall;

  assign rawLines[LINE_A] = lineA;
  assign rawLines[LINE_B] = lineB;

  for (genvar g = 0; g < NUM_LINES; g++) begin : gSync
    line_sync #(
      .STAGES   (SYNC_STAGES),
      .RESET_VAL(1'b1)
    ) uSync (
      .clk (clk),
      .rstN(rstN),
      .din (rawLines[g]),
      .dout(syncLines[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLines <= '1;
    else       prevLines <= syncLines;
  end

  assign aLevel = syncLines[LINE_A];
  assign bLevel = syncLines[LINE_B];
  assign aRise  = syncLines[LINE_A] & ~prevLines[LINE_A];
  assign bFall  = ~syncLines[LINE_B] & prevLines[LINE_B];

  // Saturating count of B falling edges while armed.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fallCount <= '0;
    end else if (strobes.clearCount) begin
      fallCount <= '0;
    end else if (strobes.countEn && bFall && (fallCount != CNT_MAX)) begin
      fallCount <= fallCount + 1'b1;
    end
  end

  // Classification of the count as seen when A rises.
  always_comb begin
    if (!bLevel)                     patClass = PC_FRAME_ERR;
    else if (fallCount == K_START)   patClass = PC_START;
    else if (fallCount == K_CRC)     patClass = PC_START_CRC;
    else if (fallCount == K_OCCUPY)  patClass = PC_OCCUPY;
    else if (fallCount >= K_RST_MIN) patClass = PC_RESET;
    else                             patClass = PC_FRAME_ERR;
  end

endmodule

// File: rtl/pattern_control.sv
module pattern_control
  import twoline_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         aLevel,
  input  logic         bLevel,
  input  logic         aRise,
  input  patClass_t    patClass,
  input  logic         dataDone,
  output ctrlStrobes_t strobes,
  output logic         startPulse,
  output logic         startCrcPulse,
  output logic         occupancyPulse,
  output logic         resetPulse,
  output logic         frameErrPulse,
  output logic         dataPhasePulse,
  output logic         busy,
  output logic         dataPhase
);

  detState_t state, stateNext;
  logic      startNext, crcNext, occNext, rstNext, errNext, dpNext;

  always_comb begin
    stateNext          = state;
    strobes.clearCount = 1'b0;
    strobes.countEn    = 1'b0;
    startNext          = 1'b0;
    crcNext            = 1'b0;
    occNext            = 1'b0;
    rstNext            = 1'b0;
    errNext            = 1'b0;
    dpNext             = 1'b0;
    unique case (state)
      ST_IDLE: begin
        strobes.clearCount = 1'b1;
        if (!aLevel && bLevel) stateNext = ST_ARMED;
      end
      ST_ARMED: begin
        strobes.countEn = 1'b1;
        if (aRise) begin
          stateNext = ST_IDLE;
          unique case (patClass)
            PC_START:     begin startNext = 1'b1; dpNext = 1'b1; stateNext = ST_DATA; end
            PC_START_CRC: begin crcNext   = 1'b1; dpNext = 1'b1; stateNext = ST_DATA; end
            PC_OCCUPY:    occNext = 1'b1;
            PC_RESET:     rstNext = 1'b1;
            default:      errNext = 1'b1;
          endcase
        end
      end
      ST_DATA: begin
        strobes.clearCount = 1'b1;
        if (dataDone) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state          <= ST_IDLE;
      startPulse     <= 1'b0;
      startCrcPulse  <= 1'b0;
      occupancyPulse <= 1'b0;
      resetPulse     <= 1'b0;
      frameErrPulse  <= 1'b0;
      dataPhasePulse <= 1'b0;
    end else begin
      state          <= stateNext;
      startPulse     <= startNext;
      startCrcPulse  <= crcNext;
      occupancyPulse <= occNext;
      resetPulse     <= rstNext;
      frameErrPulse  <= errNext;
      dataPhasePulse <= dpNext;
    end
  end

  assign busy      = (state == ST_ARMED);
  assign dataPhase = (state == ST_DATA);

endmodule

// File: rtl/twoline_pattern_detect.sv
module twoline_pattern_detect
  import twoline_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int CNT_W         = 4,
  parameter int START_CNT     = 4,
  parameter int START_CRC_CNT = 6,
  parameter int OCCUPY_CNT    = 8,
  parameter int RESET_MIN     = 14
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineA,
  input  logic lineB,
  input  logic dataDone,
  output logic startPulse,
  output logic startCrcPulse,
  output logic occupancyPulse,
  output logic resetPulse,
  output logic frameErrPulse,
  output logic dataPhasePulse,
  output logic busy,
  output logic dataPhase
);

  ctrlStrobes_t strobes;
  patClass_t    patClass;
  logic         aLevel, bLevel, aRise;

  pattern_datapath #(
    .SYNC_STAGES  (SYNC_STAGES),
    .CNT_W        (CNT_W),
    .START_CNT    (START_CNT),
    .START_CRC_CNT(START_CRC_CNT),
    .OCCUPY_CNT   (OCCUPY_CNT),
    .RESET_MIN    (RESET_MIN)
  ) uDatapath (
    .clk     (clk),
    .rstN    (rstN),
    .lineA   (lineA),
    .lineB   (lineB),
    .strobes (strobes),
    .aLevel  (aLevel),
    .bLevel  (bLevel),
    .aRise   (aRise),
    .patClass(patClass)
  );

  pattern_control uControl (
    .clk           (clk),
    .rstN          (rstN),
    .aLevel        (aLevel),
    .bLevel        (bLevel),
    .aRise         (aRise),
    .patClass      (patClass),
    .dataDone      (dataDone),
    .strobes       (strobes),
    .startPulse    (startPulse),
    .startCrcPulse (startCrcPulse),
    .occupancyPulse(occupancyPulse),
    .resetPulse    (resetPulse),
    .frameErrPulse (frameErrPulse),
    .dataPhasePulse(dataPhasePulse),
    .busy          (busy),
    .dataPhase     (dataPhase)
  );

endmodule

// File: rtl/pattern_detect_checker.sv
module pattern_detect_checker (
  input logic clk,
  input logic rstN,
  input logic aLevel,
  input logic bLevel,
  input logic startPulse,
  input logic startCrcPulse,
  input logic occupancyPulse,
  input logic resetPulse,
  input logic frameErrPulse,
  input logic dataPhasePulse,
  input logic busy,
  input logic dataPhase
);

  logic [4:0] outcomes;
  assign outcomes = {frameErrPulse, resetPulse, occupancyPulse, startCrcPulse, startPulse};

  a_r9_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(outcomes));

  a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (|outcomes) |=> !(|outcomes));

  a_r10_pulse_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    (|outcomes) |-> $past(busy));

  a_r10_busy_ends_with_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (|outcomes));

  a_r1_arm_condition: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(!aLevel && bLevel));

  a_r11_data_no_busy: assert property (@(posedge clk) disable iff (!rstN)
    dataPhase |-> !busy);

  a_r3_enter_data: assert property (@(posedge clk) disable iff (!rstN)
    dataPhasePulse |-> (dataPhase && (startPulse || startCrcPulse)));

  a_r5_stay_search: assert property (@(posedge clk) disable iff (!rstN)
    (occupancyPulse || resetPulse || frameErrPulse) |-> (!dataPhase && !dataPhasePulse));

endmodule

bind twoline_pattern_detect pattern_detect_checker uChecker (
  .clk           (clk),
  .rstN          (rstN),
  .aLevel        (aLevel),
  .bLevel        (bLevel),
  .startPulse    (startPulse),
  .startCrcPulse (startCrcPulse),
  .occupancyPulse(occupancyPulse),
  .resetPulse    (resetPulse),
  .frameErrPulse (frameErrPulse),
  .dataPhasePulse(dataPhasePulse),
  .busy          (busy),
  .dataPhase     (dataPhase)
);

// File: tb/sim_twoline_pattern_detect.sv
`timescale 1ns/1ps
module sim_twoline_pattern_detect;

  logic clk = 1'b0;
  logic rstN, lineA, lineB, dataDone;
  logic startPulse, startCrcPulse, occupancyPulse, resetPulse;
  logic frameErrPulse, dataPhasePulse, busy, dataPhase;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Event code bits: [5]=dataPhasePulse [4]=frameErr [3]=reset [2]=occupancy [1]=startCrc [0]=start
  localparam logic [5:0] EV_START = 6'b100001;
  localparam logic [5:0] EV_CRC   = 6'b100010;
  localparam logic [5:0] EV_OCC   = 6'b000100;
  localparam logic [5:0] EV_RST   = 6'b001000;
  localparam logic [5:0] EV_ERR   = 6'b010000;

  logic [5:0] expQ[$];
  string      reqQ[$];

  always #2 clk = ~clk;

  twoline_pattern_detect u0 (
    .clk(clk), .rstN(rstN), .lineA(lineA), .lineB(lineB), .dataDone(dataDone),
    .startPulse(startPulse), .startCrcPulse(startCrcPulse),
    .occupancyPulse(occupancyPulse), .resetPulse(resetPulse),
    .frameErrPulse(frameErrPulse), .dataPhasePulse(dataPhasePulse),
    .busy(busy), .dataPhase(dataPhase)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: every outcome pulse seen must match the next queued expectation.
  always @(negedge clk) begin
    logic [5:0] obs;
    obs = {dataPhasePulse, frameErrPulse, resetPulse, occupancyPulse, startCrcPulse, startPulse};
    if (rstN && obs != 6'b0) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9 unexpected pulse", int'(obs), 0);
      end else begin
        logic [5:0] e;
        string r;
        e = expQ.pop_front();
        r = reqQ.pop_front();
        check(obs == e, r, int'(obs), int'(e));
      end
    end
  end

  task automatic hold(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic setLines(input logic a, input logic b);
    @(posedge clk); #1;
    lineA = a;
    lineB = b;
  endtask

  task automatic expectEv(input logic [5:0] e, input string r);
    expQ.push_back(e);
    reqQ.push_back(r);
  endtask

  // Arm, emit n B falls, optionally drop B again, then raise A.
  task automatic sendPattern(input int n, input bit bLowEnd, input bit armExp, input string r);
    setLines(1'b0, 1'b1);
    hold(5);
    @(negedge clk);
    check(busy == armExp, {r, " R10 busy after arm"}, int'(busy), int'(armExp));
    for (int i = 0; i < n; i++) begin
      setLines(1'b0, 1'b0);
      hold(3);
      setLines(1'b0, 1'b1);
      hold(3);
    end
    if (bLowEnd) begin
      setLines(1'b0, 1'b0);
      hold(3);
    end
    setLines(1'b1, bLowEnd ? 1'b0 : 1'b1);
    hold(6);
    @(negedge clk);
    check(busy == 1'b0, {r, " R10 busy cleared"}, int'(busy), 0);
    setLines(1'b1, 1'b1);
    hold(6);
    @(negedge clk);
    check(expQ.size() == 0, {r, " R9 outcome produced"}, expQ.size(), 0);
  endtask

  task automatic finishData();
    @(negedge clk);
    check(dataPhase == 1'b1, "R11 dataPhase high", int'(dataPhase), 1);
    @(posedge clk); #1 dataDone = 1'b1;
    @(posedge clk); #1 dataDone = 1'b0;
    @(negedge clk);
    check(dataPhase == 1'b0, "R11 dataPhase cleared", int'(dataPhase), 0);
  endtask

  initial begin
    rstN = 1'b0; lineA = 1'b1; lineB = 1'b1; dataDone = 1'b0;
    hold(5);
    @(negedge clk);
    check({startPulse, startCrcPulse, occupancyPulse, resetPulse, frameErrPulse,
           dataPhasePulse, busy, dataPhase} == 8'b0, "R12 reset outputs",
          int'({startPulse, startCrcPulse, occupancyPulse, resetPulse, frameErrPulse,
                dataPhasePulse, busy, dataPhase}), 0);
    @(posedge clk); #1 rstN = 1'b1;
    hold(6);

    // R1: A low with B low must not arm; B rising then arms.
    setLines(1'b1, 1'b0); hold(4);
    setLines(1'b0, 1'b0); hold(6);
    @(negedge clk);
    check(busy == 1'b0, "R1 no arm with both low", int'(busy), 0);
    setLines(1'b0, 1'b1); hold(5);
    @(negedge clk);
    check(busy == 1'b1, "R1 arm with A low B high", int'(busy), 1);
    expectEv(EV_ERR, "R7 count 0");
    setLines(1'b1, 1'b1); hold(8);
    @(negedge clk);
    check(expQ.size() == 0, "R7 count 0 resolved", expQ.size(), 0);

    // R2: four falls, hold A low long; no outcome until A rises.
    expectEv(EV_START, "R3 start after hold");
    setLines(1'b0, 1'b1); hold(5);
    for (int i = 0; i < 4; i++) begin
      setLines(1'b0, 1'b0); hold(3);
      setLines(1'b0, 1'b1); hold(3);
    end
    hold(40);
    @(negedge clk);
    check(expQ.size() == 1 && busy, "R2 no outcome before A rises", expQ.size(), 1);
    setLines(1'b1, 1'b1); hold(8);
    @(negedge clk);
    check(expQ.size() == 0, "R2 outcome on A rise", expQ.size(), 0);
    finishData();

    expectEv(EV_START, "R3 start count 4");
    sendPattern(4, 1'b0, 1'b1, "R3");
    // R11: occupancy-shaped activity during the data phase is ignored.
    sendPattern(8, 1'b0, 1'b0, "R11");
    finishData();

    expectEv(EV_CRC, "R4 start-crc count 6");
    sendPattern(6, 1'b0, 1'b1, "R4");
    finishData();

    expectEv(EV_OCC, "R5 occupancy count 8");
    sendPattern(8, 1'b0, 1'b1, "R5");
    @(negedge clk);
    check(dataPhase == 1'b0, "R5 no data phase", int'(dataPhase), 0);

    expectEv(EV_RST, "R6 reset count 14");
    sendPattern(14, 1'b0, 1'b1, "R6");
    expectEv(EV_RST, "R6 reset count 20 saturates");
    sendPattern(20, 1'b0, 1'b1, "R6");

    expectEv(EV_ERR, "R7 count 5");
    sendPattern(5, 1'b0, 1'b1, "R7");
    expectEv(EV_ERR, "R7 count 7");
    sendPattern(7, 1'b0, 1'b1, "R7");
    expectEv(EV_ERR, "R7 count 13");
    sendPattern(13, 1'b0, 1'b1, "R7");

    // R8: count reaches 4 but B is low when A rises.
    expectEv(EV_ERR, "R8 B low at A rise");
    sendPattern(3, 1'b1, 1'b1, "R8");
    @(negedge clk);
    check(dataPhase == 1'b0, "R8 no data phase", int'(dataPhase), 0);

    // Detector still usable afterwards.
    expectEv(EV_CRC, "R4 start-crc after errors");
    sendPattern(6, 1'b0, 1'b1, "R4");
    finishData();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule